// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous SRAM

This block sits beside a burst-capable synchronous SRAM and produces the address for each beat of a burst. A burst opens when either of two start strobes is sampled high. One strobe serves a processor and the other serves a cache controller. On that edge the block captures a full base address. Later beats come from an internal 2-bit beat counter, which steps only on edges where the advance input is high.

The two low address bits are built from the captured starting bits and the beat count. The order is either linear (modulo-4 add) or interleaved (XOR), and a select input picks which one. The bits above those two stay fixed for the whole burst. The block does not store or move data. A board-level select that is left unconnected should be tied high so that interleaved order is used.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low and on the first sample after it, `addr_out` is all zeros and `burst_active` is 0.
- R2: An edge with `strobe_proc` or `strobe_cache` high captures `addr_in`. After that edge, `addr_out` equals the captured value and `burst_active` is 1.
- R3: When the registered order select is 0, `addr_out[1:0]` equals (start bits + beat count) mod 4. For example, a start of 1 gives 1, 2, 3, 0.
- R4: When the registered order select is 1, `addr_out[1:0]` equals start bits XOR beat count. For example, a start of 1 gives 1, 0, 3, 2.
- R5: The beat count grows by one only on an edge where `adv` is high, a burst is open and no strobe is high. On any other edge without a strobe, the count holds.
- R6: `addr_out[ADDR_W-1:2]` does not change on edges without a strobe.
- R7: A strobe during an open burst captures the new address and sets the beat count to 0. This happens even if `adv` is high on the same edge.
- R8: After the fourth beat, the count wraps to 0 and keeps cycling while `adv` stays high.
- R9: Before the first strobe after reset, `adv` has no effect: `addr_out` stays zero and `burst_active` stays 0.
- R10: `order_sel` is sampled on every rising edge. A change in it re-maps the low bits from the next sample onward, and the beat count is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_proc | input | 1 | Processor-side burst start |
| strobe_cache | input | 1 | Cache-controller-side burst start |
| adv | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_in | input | ADDR_W | Base address captured on a start |
| addr_out | output | ADDR_W | Address of the current beat |
| burst_active | output | 1 | High once a burst has been opened |

## Verification
The bench sweeps every starting low-bit value in both orders and from both strobes. Each burst runs through nine advances with stalls mixed in. This separates the add sequence from the XOR sequence, shows that the count wraps instead of stopping, and shows that a stall holds the beat. Separate patterns test the following:
- advancing before any burst has opened;
- restarting with a strobe and an advance on the same edge, which shows that a strobe takes priority over an advance;
- flipping the order select in the middle of a burst, which shows that only the mapping changes and the beat count is kept.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_proc,
  input  logic              strobe_cache,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);
  localparam int BEAT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic              order_q;
  logic              open_q;
  logic              start;
  logic [BEAT_W-1:0] low_lin, low_ilv;

  assign start = strobe_proc | strobe_cache;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      beat_q  <= '0;
      order_q <= 1'b1;
      open_q  <= 1'b0;
    end else begin
      order_q <= order_sel;
      if (start) begin
        base_q <= addr_in;
        beat_q <= '0;
        open_q <= 1'b1;
      end else if (adv && open_q) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign low_lin      = base_q[BEAT_W-1:0] + beat_q;
  assign low_ilv      = base_q[BEAT_W-1:0] ^ beat_q;
  assign addr_out     = {base_q[ADDR_W-1:BEAT_W], order_q ? low_ilv : low_lin};
  assign burst_active = open_q;
endmodule

module burst_addr_gen_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_proc,
  input logic              strobe_cache,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_active
);
  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_proc || strobe_cache) |=> (addr_out == $past(addr_in)));

  // R2
  open_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_proc || strobe_cache) |=> burst_active);

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_proc || strobe_cache) |=> $stable(addr_out[ADDR_W-1:2]));

  // R8
  never_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(burst_active));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active |-> (addr_out == '0));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sp = 1'b0, sc = 1'b0, adv = 1'b0, osel = 1'b1;
  logic [AW-1:0] ain = '0;
  logic [AW-1:0] aout;
  logic          act;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base = '0;
  int            m_cnt = 0;
  bit            m_ord = 1'b1;
  bit            m_open = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .strobe_proc(sp), .strobe_cache(sc),
    .adv(adv), .order_sel(osel), .addr_in(ain),
    .addr_out(aout), .burst_active(act)
  );

  function automatic logic [AW-1:0] expect_addr();
    logic [1:0] s, c, lo;
    s  = m_base[1:0];
    c  = 2'(m_cnt);
    lo = m_ord ? (s ^ c) : 2'(s + c);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(bit p, bit c, bit a, bit o, logic [AW-1:0] addr, string req);
    logic [AW-1:2] up_before;
    up_before = aout[AW-1:2];
    sp = p; sc = c; adv = a; osel = o; ain = addr;
    m_ord = o;
    if (p || c) begin
      m_base = addr; m_cnt = 0; m_open = 1'b1;
    end else if (a && m_open) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(posedge clk);
    @(negedge clk);
    check(req, aout, expect_addr());
    check(req, {{(AW-1){1'b0}}, act}, {{(AW-1){1'b0}}, m_open});
    // R6
    if (!(p || c)) check("R6", {aout[AW-1:2], 2'b00}, {up_before, 2'b00});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", aout, '0);
    check("R1", {{(AW-1){1'b0}}, act}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", aout, '0);
    check("R1", {{(AW-1){1'b0}}, act}, '0);

    for (int i = 0; i < 5; i++) step(0, 0, 1, i[0], 17'h1ABCD, "R9");

    for (int o = 0; o < 2; o++)
      for (int src = 0; src < 2; src++)
        for (int s = 0; s < 4; s++) begin
          logic [AW-1:0] b;
          b = AW'((s * 17'h0B5) ^ (o * 17'h15550) ^ (src * 17'h0A0A4));
          b[1:0] = 2'(s);
          step(src == 0, src == 1, 0, o[0], b, "R2");
          for (int k = 0; k < 12; k++) begin
            bit a;
            a = (k % 4) != 3;
            if (!a) step(0, 0, 0, o[0], '1, "R5");
            else if (m_cnt == 3) step(0, 0, 1, o[0], '1, "R8");
            else step(0, 0, 1, o[0], '1, o ? "R4" : "R3");
          end
        end

    step(1, 0, 0, 0, 17'h12346, "R2");
    step(0, 0, 1, 0, 17'h0, "R3");
    step(0, 1, 1, 0, 17'h0FF01, "R7");
    step(1, 1, 1, 1, 17'h0FF03, "R7");
    step(0, 0, 1, 1, 17'h0, "R4");

    step(1, 0, 0, 0, 17'h00A01, "R2");
    step(0, 0, 1, 0, 17'h0, "R3");
    step(0, 0, 1, 0, 17'h0, "R3");
    step(0, 0, 0, 1, 17'h0, "R10");
    step(0, 0, 0, 0, 17'h0, "R10");
    step(0, 0, 1, 1, 17'h0, "R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule